// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address presented to a synchronous memory array during a four-beat burst. When a burst starts, the full external address is captured. On each later advance, only the two low address bits move, while the upper bits stay fixed. Because the low bits simply cycle, a burst never leaves its aligned group of four words.

The low bits can follow either of two orders, chosen by a static select level. In linear order, the low bits count up modulo 4 from the captured value. In interleaved order, the low bits are the captured value XOR the beat number.

Two active-low start strobes each begin a burst, and either one cancels any burst in progress. An active-low advance steps the burst by one beat. When neither a start nor an advance is present, the address is held.

The reset input clears the block at once. It is released in step with the clock, so the block ignores its inputs at the first two rising edges after `rst_n` goes high.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `arr_addr` is 0 and the beat counter is 0, with no clock edge needed.
- R2: If `start_a_n` or `start_b_n` is low at a rising edge, `arr_addr` equals the `ext_addr` value sampled at that edge, and the beat index returns to 0.
- R3: A start strobe takes priority over `adv_n` and cancels a burst in progress at any beat.
- R4: With `order_sel` = 0 (linear), beat n has low bits equal to (loaded low bits + n) mod 4.
- R5: With `order_sel` = 1 (interleaved), beat n has low bits equal to the loaded low bits XOR n.
- R6: If both strobes are high and `adv_n` is high at an edge, `arr_addr` is unchanged.
- R7: Bits 16..2 of `arr_addr` keep their loaded value until the next start, whatever `ext_addr` does in between.
- R8: An advance from beat 3 returns to beat 0, so the fifth address of a burst equals the loaded address.
- R9: `order_sel` is not clocked. A change of its level changes `arr_addr` in the same clock phase, and the beat index is not affected.
- R10: After `rst_n` rises, start strobes at the first two rising edges are ignored, and a strobe at the third edge loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised to `clk` |
| ext_addr | input | 17 | Word address captured when a burst starts |
| start_a_n | input | 1 | Active-low burst start strobe, first source |
| start_b_n | input | 1 | Active-low burst start strobe, second source |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_sel | input | 1 | Static select level: 0 = linear order, 1 = interleaved order |
| arr_addr | output | 17 | Current array word address |

## Verification
A start or an advance presented before a rising edge appears on `arr_addr` right after that edge, since one register stage sits between the inputs and the output. The bench changes its inputs on the falling edge and reads `arr_addr` on the next falling edge. A change on `order_sel` has no register in its path, so the bench reads it back 1 ns after the change, within the same low phase. After reset is released, the three-edge delay of R10 is checked edge by edge. Each run compares the output against a bench model that tracks only the loaded base address and the beat count.

// File: rtl/bas_pkg.sv
package bas_pkg;
  // Decoded per-cycle command for the sequencer state
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2
  } bas_cmd_e;

  // Start strobes win over advance; advance wins over hold
  function automatic bas_cmd_e decode_cmd(input logic sa_n, input logic sb_n,
                                          input logic adv_n);
    if (!sa_n || !sb_n) return CMD_LOAD;
    else if (!adv_n)    return CMD_STEP;
    else                return CMD_HOLD;
  endfunction
endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_shift
      always_comb chain_d[g] = chain_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
#(
  parameter int SEQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bas_cmd_e         cmd,
  output logic [SEQ_W-1:0] beat
);
  logic [SEQ_W-1:0] beat_q;
  logic [SEQ_W-1:0] beat_d;
  logic             beat_en;

  always_comb begin
    beat_en = (cmd != CMD_HOLD);
    beat_d  = beat_q;
    if (cmd == CMD_LOAD)      beat_d = '0;
    else if (cmd == CMD_STEP) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat = beat_q;

  // R2: a load always restarts at beat zero
  assert_beat_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (beat == '0));

  // R8: stepping past the last beat comes back to the first
  assert_beat_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_STEP) && (beat == {SEQ_W{1'b1}})) |=> (beat == '0));
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
  parameter int SEQ_W = 2
) (
  input  logic [SEQ_W-1:0] base_lo,
  input  logic [SEQ_W-1:0] beat,
  input  logic             order_sel,
  output logic [SEQ_W-1:0] seq_lo
);
  logic [SEQ_W-1:0] lin_lo;
  logic [SEQ_W-1:0] ilv_lo;

  // Linear: modulo-2^SEQ_W sum; interleaved: bitwise XOR
  assign lin_lo = base_lo + beat;

  genvar b;
  generate
    for (b = 0; b < SEQ_W; b++) begin : g_ilv
      assign ilv_lo[b] = base_lo[b] ^ beat[b];
    end
  endgenerate

  assign seq_lo = order_sel ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SEQ_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              start_a_n,
  input  logic              start_b_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int HI_W = ADDR_W - SEQ_W;

  logic             rst_i_n;
  bas_cmd_e         cmd;
  logic [HI_W-1:0]  hi_q;
  logic [HI_W-1:0]  hi_d;
  logic [SEQ_W-1:0] base_lo_q;
  logic [SEQ_W-1:0] base_lo_d;
  logic             load_en;
  logic [SEQ_W-1:0] beat;
  logic [SEQ_W-1:0] seq_lo;

  bas_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    cmd       = decode_cmd(start_a_n, start_b_n, adv_n);
    load_en   = (cmd == CMD_LOAD);
    hi_d      = ext_addr[ADDR_W-1:SEQ_W];
    base_lo_d = ext_addr[SEQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hi_q      <= '0;
      base_lo_q <= '0;
    end else if (load_en) begin
      hi_q      <= hi_d;
      base_lo_q <= base_lo_d;
    end
  end

  bas_beat_ctr #(.SEQ_W(SEQ_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_i_n),
    .cmd   (cmd),
    .beat  (beat)
  );

  bas_order_map #(.SEQ_W(SEQ_W)) u_map (
    .base_lo   (base_lo_q),
    .beat      (beat),
    .order_sel (order_sel),
    .seq_lo    (seq_lo)
  );

  assign arr_addr = {hi_q, seq_lo};

  // R2: either strobe captures the external address (beat 0 maps to base in both orders)
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!start_a_n || !start_b_n) |=> (arr_addr == $past(ext_addr)));

  // R7: upper bits move only on a load
  assert_upper_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start_a_n && start_b_n) |=>
      (arr_addr[ADDR_W-1:SEQ_W] == $past(arr_addr[ADDR_W-1:SEQ_W])));

  // R6: idle cycle keeps the address unless the order level moved
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start_a_n && start_b_n && adv_n) |=>
      (!$stable(order_sel) || $stable(arr_addr)));
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] ext_addr;
  logic        start_a_n, start_b_n, adv_n, order_sel;
  logic [16:0] arr_addr;

  int checks = 0;
  int errors = 0;
  logic [16:0] m_base;
  int          m_beat;

  always #10 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .start_a_n(start_a_n), .start_b_n(start_b_n), .adv_n(adv_n),
    .order_sel(order_sel), .arr_addr(arr_addr)
  );

  function automatic logic [16:0] expect_addr(logic [16:0] base, int beat, logic ord);
    logic [1:0] lo;
    if (ord) lo = base[1:0] ^ 2'(beat);
    else     lo = 2'((int'(base[1:0]) + beat) % 4);
    return {base[16:2], lo};
  endfunction

  task automatic check(string req, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", req, got, exp);
    end
  endtask

  // drive at falling edge, one rising edge passes, sample at next falling edge
  task automatic cycle(logic sa, logic sb, logic adv, logic [16:0] a);
    start_a_n = sa; start_b_n = sb; adv_n = adv; ext_addr = a;
    @(negedge clk);
  endtask

  task automatic do_load(logic [16:0] a, bit use_b, string req);
    if (use_b) cycle(1'b1, 1'b0, 1'b1, a);
    else       cycle(1'b0, 1'b1, 1'b1, a);
    m_base = a; m_beat = 0;
    check(req, arr_addr, a);
  endtask

  task automatic do_step(string req);
    cycle(1'b1, 1'b1, 1'b0, ~m_base);
    m_beat = (m_beat + 1) % 4;
    check(req, arr_addr, expect_addr(m_base, m_beat, order_sel));
  endtask

  initial begin
    rst_n = 1'b0; start_a_n = 1'b1; start_b_n = 1'b1; adv_n = 1'b1;
    order_sel = 1'b0; ext_addr = '0;
    #3;
    check("R1", arr_addr, 17'h0);
    repeat (3) @(negedge clk);
    check("R1", arr_addr, 17'h0);

    // R10: release, strobes at edges one and two ignored, edge three loads
    rst_n = 1'b1;
    cycle(1'b0, 1'b1, 1'b1, 17'h1ABCD);
    check("R10", arr_addr, 17'h0);
    cycle(1'b0, 1'b1, 1'b1, 17'h1ABCD);
    check("R10", arr_addr, 17'h0);
    cycle(1'b0, 1'b1, 1'b1, 17'h1ABCD);
    check("R10", arr_addr, 17'h1ABCD);

    // sweep both orders, all start offsets, both strobes, two upper patterns
    for (int ord = 0; ord < 2; ord++) begin
      order_sel = ord[0];
      for (int lo = 0; lo < 4; lo++) begin
        for (int s = 0; s < 2; s++) begin
          for (int hp = 0; hp < 2; hp++) begin
            logic [16:0] a;
            a = {(hp == 0) ? 15'h5A5A : 15'h7FFF, 2'(lo)};
            do_load(a, s[0], "R2");
            do_step(ord ? "R5" : "R4");
            cycle(1'b1, 1'b1, 1'b1, 17'h00000);
            check("R6", arr_addr, expect_addr(m_base, m_beat, order_sel));
            do_step(ord ? "R5" : "R4");
            do_step("R7");
            do_step("R8");
            check("R8", arr_addr, a);
          end
        end
      end
    end

    // R3: start during a burst with advance also low
    order_sel = 1'b0;
    do_load(17'h12345, 1'b0, "R2");
    do_step("R4");
    do_step("R4");
    cycle(1'b1, 1'b0, 1'b0, 17'h0F00E);
    m_base = 17'h0F00E; m_beat = 0;
    check("R3", arr_addr, 17'h0F00E);
    do_step("R4");

    // R9: level change seen within the same phase, beat kept
    do_load(17'h00021, 1'b0, "R2");
    do_step("R4");
    #1 order_sel = 1'b1;
    #1 check("R9", arr_addr, 17'h00020);
    #1 order_sel = 1'b0;
    #1 check("R9", arr_addr, 17'h00022);
    order_sel = 1'b1;
    do_step("R9");

    // R1: asynchronous clear mid-burst
    #2 rst_n = 1'b0;
    #1 check("R1", arr_addr, 17'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule